// File: doc/BRIEF.md
# Event-Triggered Delay Pulser

This block is one trigger output channel in an event receiver. On every tick of the recovered event clock it sees one decoded 8-bit event code and a valid flag. If the code equals the channel's programmed code and the channel is enabled, the channel counts a programmable number of clock ticks. It then drives an output pulse that lasts a programmable number of ticks. No software sits between the arriving code and the output edge.

Software sets the channel through a small register port: a one-cycle write strobe and a combinational read mux. New settings reach the timing logic only while the channel is idle. A write made during a delay or a pulse is held and takes effect once the channel is idle again. A mode bit decides what a second matching code does while the channel is busy: it either restarts the delay, or it is dropped. An invert bit sets the idle level of the output.

Top module: `evt_pulse_chan`

## Requirements
- R1: After a synchronous reset, every register reads zero, the channel is idle and `pulse_o` is low.
- R2: A match is a cycle in which `evt_valid` is 1, `evt_code` equals the code register (address 0, bits 7:0), and the enable bit (control bit 0) is 1. Any other code, and any code while the channel is disabled, leaves the output and the status unchanged.
- R3: With delay value D (address 1), the pulse begins D+1 clock cycles after the match cycle. D = 0 starts the pulse on the cycle right after the match, and each step of D is one clock period.
- R4: With width value W (address 2, bits 15:0) and W ≥ 1, the output stays active for exactly W cycles and the channel then returns to idle. A match while W = 0 produces no pulse and leaves the channel idle.
- R5: The delay register holds 28 bits (bits 27:0), which covers more than 2 s at a 119 MHz event clock. A written value reads back masked to 28 bits.
- R6: With control bit 2 = 0, a match while the channel is busy (during the delay or the pulse) restarts the sequence. The new delay is counted from that match, using the current settings.
- R7: With control bit 2 = 1, a match while the channel is busy is ignored, and the sequence already running continues unchanged.
- R8: Writes made while the channel is busy leave the active settings and their readback unchanged. Each held value is applied on the first clock edge at which the channel is idle. A write in that same cycle takes precedence over a held value for the same register.
- R9: When control bit 1 is 1, `pulse_o` is inverted: it idles high and drives low for the pulse.
- R10: The read mux maps addresses 0, 1, 2 and 3 to code, delay, width and control (bits 2:0). Address 4 bit 0 reads 1 while the channel is busy. Unused addresses and unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered event clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | Decoded event code present this cycle |
| evt_code | input | 8 | Decoded event code |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data, combinational |
| pulse_o | output | 1 | Trigger output |

## Verification
The assertions assume that reset is asserted for at least one edge before any traffic, and that `wr_en`, `evt_valid` and the codes are clean, clock-synchronous levels. They also assume that settings change only through the write port, so that the active values are frozen for as long as the channel is busy. The bench drives every input just after the falling edge and holds each strobe for exactly one rising edge. Its programmed delays and widths stay small enough that every sequence, including the restart and drop cases, completes inside the run.

// File: rtl/evp_pkg.sv
`timescale 1ns/1ps
package evp_pkg;

    localparam int ADR_W = 3;

    localparam logic [ADR_W-1:0] ADR_CODE = 3'd0;
    localparam logic [ADR_W-1:0] ADR_DLY  = 3'd1;
    localparam logic [ADR_W-1:0] ADR_WID  = 3'd2;
    localparam logic [ADR_W-1:0] ADR_CTRL = 3'd3;
    localparam logic [ADR_W-1:0] ADR_STAT = 3'd4;

    localparam int CTRL_W = 3;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_WAIT = 2'd1,
        SEQ_FIRE = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic drop_busy;   // 1: ignore matches while busy, 0: restart
        logic invert;      // output idle level high
        logic enable;      // accept matches
    } ctrl_t;

    function automatic logic code_hit(input logic vld, input logic [7:0] rx,
                                      input logic [7:0] prog, input logic en);
        return vld && en && (rx == prog);
    endfunction

endpackage

// File: rtl/evp_hold_reg.sv
`timescale 1ns/1ps
module evp_hold_reg #(
    parameter int W = 8,
    parameter logic [evp_pkg::ADR_W-1:0] FIELD_ADR = '0
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      idle,
    input  logic                      wr_en,
    input  logic [evp_pkg::ADR_W-1:0] wr_addr,
    input  logic [W-1:0]              din,
    output logic [W-1:0]              q
);
    logic         sel;
    logic [W-1:0] held;
    logic         held_v;

    assign sel = wr_en && (wr_addr == FIELD_ADR);

    always_ff @(posedge clk) begin
        if (rst) begin
            q      <= '0;
            held   <= '0;
            held_v <= 1'b0;
        end else if (idle) begin
            if (sel) begin
                q <= din;
            end else if (held_v) begin
                q <= held;
            end
            held_v <= 1'b0;
        end else if (sel) begin
            held   <= din;
            held_v <= 1'b1;
        end
    end

    // Active value frozen while the channel is busy.
    p_frozen_busy_r8: assert property (@(posedge clk) disable iff (rst)
        !idle |=> $stable(q));

    // A held value lands on the first idle edge unless overwritten.
    p_held_applies_r8: assert property (@(posedge clk) disable iff (rst)
        (idle && held_v && !sel) |=> (q == $past(held)));

endmodule

// File: rtl/evp_seq.sv
`timescale 1ns/1ps
module evp_seq
    import evp_pkg::*;
#(
    parameter int DLY_W = 28,
    parameter int WID_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit,
    input  logic             drop_busy,
    input  logic [DLY_W-1:0] dly,
    input  logic [WID_W-1:0] wid,
    output logic             fire,
    output logic             busy
);
    localparam logic [DLY_W-1:0] D_ONE = DLY_W'(1);
    localparam logic [WID_W-1:0] W_ONE = WID_W'(1);

    seq_state_t       st, st_n;
    logic [DLY_W-1:0] dcnt, dcnt_n;
    logic [WID_W-1:0] wcnt, wcnt_n;
    logic [WID_W-1:0] wlat, wlat_n;
    logic             take;

    assign take = hit && ((st == SEQ_IDLE) || !drop_busy);

    always_comb begin
        st_n   = st;
        dcnt_n = dcnt;
        wcnt_n = wcnt;
        wlat_n = wlat;
        if (take) begin
            if (wid == '0) begin
                st_n = SEQ_IDLE;
            end else begin
                wlat_n = wid;
                if (dly == '0) begin
                    st_n   = SEQ_FIRE;
                    wcnt_n = wid;
                end else begin
                    st_n   = SEQ_WAIT;
                    dcnt_n = dly;
                end
            end
        end else begin
            case (st)
                SEQ_WAIT: begin
                    if (dcnt == D_ONE) begin
                        st_n   = SEQ_FIRE;
                        wcnt_n = wlat;
                    end else begin
                        dcnt_n = dcnt - D_ONE;
                    end
                end
                SEQ_FIRE: begin
                    if (wcnt == W_ONE) begin
                        st_n = SEQ_IDLE;
                    end else begin
                        wcnt_n = wcnt - W_ONE;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= SEQ_IDLE;
            dcnt <= '0;
            wcnt <= '0;
            wlat <= '0;
        end else begin
            st   <= st_n;
            dcnt <= dcnt_n;
            wcnt <= wcnt_n;
            wlat <= wlat_n;
        end
    end

    assign fire = (st == SEQ_FIRE);
    assign busy = (st != SEQ_IDLE);

    p_zero_delay_r3: assert property (@(posedge clk) disable iff (rst)
        (st == SEQ_IDLE && hit && dly == '0 && wid != '0)
        |=> (st == SEQ_FIRE && wcnt == $past(wid)));

    p_wait_ends_r3: assert property (@(posedge clk) disable iff (rst)
        (st == SEQ_WAIT && dcnt == D_ONE && !take) |=> (st == SEQ_FIRE));

    p_width_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (st == SEQ_IDLE && hit && wid == '0) |=> (st == SEQ_IDLE));

    p_fire_ends_r4: assert property (@(posedge clk) disable iff (rst)
        (st == SEQ_FIRE && wcnt == W_ONE && !take) |=> (st == SEQ_IDLE));

    p_fire_count_r4: assert property (@(posedge clk) disable iff (rst)
        (st == SEQ_FIRE) |-> (wcnt != '0));

    p_restart_r6: assert property (@(posedge clk) disable iff (rst)
        (st != SEQ_IDLE && hit && !drop_busy && dly != '0 && wid != '0)
        |=> (st == SEQ_WAIT && dcnt == $past(dly)));

    p_drop_r7: assert property (@(posedge clk) disable iff (rst)
        (st == SEQ_WAIT && dcnt > D_ONE && hit && drop_busy)
        |=> (st == SEQ_WAIT && dcnt == $past(dcnt) - D_ONE));

endmodule

// File: rtl/evt_pulse_chan.sv
`timescale 1ns/1ps
module evt_pulse_chan
    import evp_pkg::*;
#(
    parameter int CODE_W = 8,
    parameter int DLY_W  = 28,
    parameter int WID_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              evt_valid,
    input  logic [CODE_W-1:0] evt_code,
    input  logic              wr_en,
    input  logic [ADR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              pulse_o
);
    logic [CODE_W-1:0] code_q;
    logic [DLY_W-1:0]  dly_q;
    logic [WID_W-1:0]  wid_q;
    logic [CTRL_W-1:0] ctrl_bits;
    ctrl_t             ctrl_q;
    logic              busy;
    logic              fire;
    logic              hit;
    logic              unused_wr;

    assign unused_wr = ^wr_data;
    assign ctrl_q    = ctrl_t'(ctrl_bits);

    evp_hold_reg #(.W(CODE_W), .FIELD_ADR(ADR_CODE)) u_code (
        .clk(clk), .rst(rst), .idle(!busy), .wr_en(wr_en), .wr_addr(wr_addr),
        .din(wr_data[CODE_W-1:0]), .q(code_q));

    evp_hold_reg #(.W(DLY_W), .FIELD_ADR(ADR_DLY)) u_dly (
        .clk(clk), .rst(rst), .idle(!busy), .wr_en(wr_en), .wr_addr(wr_addr),
        .din(wr_data[DLY_W-1:0]), .q(dly_q));

    evp_hold_reg #(.W(WID_W), .FIELD_ADR(ADR_WID)) u_wid (
        .clk(clk), .rst(rst), .idle(!busy), .wr_en(wr_en), .wr_addr(wr_addr),
        .din(wr_data[WID_W-1:0]), .q(wid_q));

    evp_hold_reg #(.W(CTRL_W), .FIELD_ADR(ADR_CTRL)) u_ctrl (
        .clk(clk), .rst(rst), .idle(!busy), .wr_en(wr_en), .wr_addr(wr_addr),
        .din(wr_data[CTRL_W-1:0]), .q(ctrl_bits));

    assign hit = code_hit(evt_valid, evt_code, code_q, ctrl_q.enable);

    evp_seq #(.DLY_W(DLY_W), .WID_W(WID_W)) u_seq (
        .clk(clk), .rst(rst), .hit(hit), .drop_busy(ctrl_q.drop_busy),
        .dly(dly_q), .wid(wid_q), .fire(fire), .busy(busy));

    assign pulse_o = fire ^ ctrl_q.invert;

    always_comb begin
        case (rd_addr)
            ADR_CODE: rd_data = DATA_W'(code_q);
            ADR_DLY:  rd_data = DATA_W'(dly_q);
            ADR_WID:  rd_data = DATA_W'(wid_q);
            ADR_CTRL: rd_data = DATA_W'(ctrl_bits);
            ADR_STAT: rd_data = DATA_W'(busy);
            default:  rd_data = '0;
        endcase
    end

    // Disabled and idle: nothing can start the channel.
    p_disabled_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.enable && !busy) |=> !busy);

    // Idle output level follows the invert bit.
    p_idle_level_r9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (pulse_o == ctrl_q.invert));

    // Reset leaves the channel idle with a low output.
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (!busy && !pulse_o));

endmodule

// File: tb/evt_pulse_chan_tb.sv
`timescale 1ns/1ps
module evt_pulse_chan_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        evt_valid = 1'b0;
    logic [7:0]  evt_code = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        pulse_o;

    always #2.5 clk = ~clk;

    evt_pulse_chan u_dut (
        .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_code(evt_code),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .pulse_o(pulse_o));

    int    n_chk = 0;
    int    n_fail = 0;
    bit    checking = 1'b0;
    bit    done = 1'b0;
    string cur_tag = "R1";

    // Reference model: state 0 idle, 1 delay, 2 pulse
    int      m_st;
    longint  m_dcnt, m_wcnt, m_wlat;
    longint  cfg [4];
    longint  held [4];
    bit      held_v [4];

    function automatic longint fmask(input int k, input longint v);
        case (k)
            0: return v & 64'hFF;
            1: return v & 64'h0FFF_FFFF;
            2: return v & 64'hFFFF;
            default: return v & 64'h7;
        endcase
    endfunction

    function automatic longint exp_rd(input int a);
        if (a < 4) return cfg[a];
        if (a == 4) return (m_st != 0) ? 1 : 0;
        return 0;
    endfunction

    always @(posedge clk) begin : model
        bit idle, hit, take;
        if (rst) begin
            m_st = 0; m_dcnt = 0; m_wcnt = 0; m_wlat = 0;
            for (int k = 0; k < 4; k++) begin
                cfg[k] = 0; held[k] = 0; held_v[k] = 0;
            end
        end else begin
            idle = (m_st == 0);
            hit  = evt_valid && (longint'(evt_code) == cfg[0]) && cfg[3][0];
            take = hit && (idle || !cfg[3][2]);
            if (take) begin
                if (cfg[2] == 0) m_st = 0;
                else begin
                    m_wlat = cfg[2];
                    if (cfg[1] == 0) begin m_st = 2; m_wcnt = cfg[2]; end
                    else begin m_st = 1; m_dcnt = cfg[1]; end
                end
            end else if (m_st == 1) begin
                if (m_dcnt == 1) begin m_st = 2; m_wcnt = m_wlat; end
                else m_dcnt = m_dcnt - 1;
            end else if (m_st == 2) begin
                if (m_wcnt == 1) m_st = 0;
                else m_wcnt = m_wcnt - 1;
            end
            if (idle) begin
                for (int k = 0; k < 4; k++) begin
                    if (held_v[k]) cfg[k] = held[k];
                    held_v[k] = 0;
                end
                if (wr_en && wr_addr < 4) cfg[wr_addr] = fmask(int'(wr_addr), longint'(wr_data));
            end else if (wr_en && wr_addr < 4) begin
                held[wr_addr]   = fmask(int'(wr_addr), longint'(wr_data));
                held_v[wr_addr] = 1;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model
    always begin
        @(posedge clk);
        #1;
        if (checking && !rst) begin
            chk({cur_tag, " pulse"}, 32'(pulse_o), 32'((m_st == 2) ^ cfg[3][1]));
            chk({cur_tag, " read"}, rd_data, 32'(exp_rd(int'(rd_addr))));
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic evt(input logic [7:0] c);
        @(negedge clk); evt_valid = 1'b1; evt_code = c;
        @(negedge clk); evt_valid = 1'b0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic setrd(input logic [2:0] a);
        @(negedge clk); rd_addr = a;
    endtask

    task automatic look(input string tag, input logic [31:0] exp);
        @(posedge clk); #1;
        chk(tag, rd_data, exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] lf;
        wait_n(4);
        @(negedge clk); rst = 1'b0;
        checking = 1'b1;

        // R1: reset values
        cur_tag = "R1";
        for (int a = 0; a < 8; a++) begin
            setrd(3'(a));
            look("R1 reset read", 32'h0);
        end
        @(posedge clk); #1;
        chk("R1 reset output", 32'(pulse_o), 32'h0);

        // R5 / R10: register map and masking
        cur_tag = "R10";
        wr(3'd0, 32'hFFFF_FF5A);
        setrd(3'd0); look("R10 code", 32'h5A);
        cur_tag = "R5";
        wr(3'd1, 32'hFFFF_FFFF);
        setrd(3'd1); look("R5 delay mask", 32'h0FFF_FFFF);
        cur_tag = "R10";
        wr(3'd2, 32'h0001_2345);
        setrd(3'd2); look("R10 width mask", 32'h2345);
        setrd(3'd6); look("R10 unused addr", 32'h0);

        wr(3'd1, 32'd2);
        wr(3'd2, 32'd3);

        // R2: disabled, wrong code, then match
        cur_tag = "R2";
        setrd(3'd4);
        evt(8'h5A); wait_n(8);
        wr(3'd3, 32'd1);
        evt(8'h5B); wait_n(8);
        evt(8'h5A); wait_n(10);

        // R3: zero and nonzero delay
        cur_tag = "R3";
        wr(3'd1, 32'd0); wr(3'd2, 32'd1);
        evt(8'h5A); wait_n(4);
        wr(3'd1, 32'd5); wr(3'd2, 32'd4);
        evt(8'h5A); wait_n(14);

        // R4: zero width
        cur_tag = "R4";
        wr(3'd2, 32'd0);
        evt(8'h5A); wait_n(6);
        wr(3'd2, 32'd3);
        evt(8'h5A); wait_n(10);

        // R6: restart mode
        cur_tag = "R6";
        wr(3'd1, 32'd10); wr(3'd3, 32'd1);
        evt(8'h5A); wait_n(4);
        evt(8'h5A); wait_n(20);
        evt(8'h5A); wait_n(10);
        evt(8'h5A); wait_n(20);

        // R7: drop while busy
        cur_tag = "R7";
        wr(3'd3, 32'd5);
        evt(8'h5A); wait_n(4);
        evt(8'h5A); wait_n(7);
        evt(8'h5A); wait_n(16);

        // R8: writes while busy are held
        cur_tag = "R8";
        setrd(3'd1);
        evt(8'h5A);
        wr(3'd1, 32'd3);
        look("R8 held delay", 32'd10);
        wait_n(20);
        look("R8 applied delay", 32'd3);
        evt(8'h5A); wait_n(10);

        // R9: inverted output
        cur_tag = "R9";
        wr(3'd3, 32'd3);
        evt(8'h5A); wait_n(10);

        // R10: busy status
        cur_tag = "R10";
        wr(3'd3, 32'd1); wr(3'd1, 32'd10);
        evt(8'h5A);
        setrd(3'd4);
        look("R10 busy set", 32'd1);
        wait_n(20);
        look("R10 busy clear", 32'd0);

        // Mixed traffic against the model
        cur_tag = "R2";
        lf = 32'hACE1_1234;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            evt_valid = lf[0] & lf[1];
            evt_code  = lf[3] ? 8'h5A : lf[15:8];
            rd_addr   = lf[26:24];
            wr_en     = (lf[31:28] == 4'hF);
            wr_addr   = {1'b0, lf[5:4]};
            case (lf[5:4])
                2'd0: wr_data = lf[6] ? 32'h5A : 32'h33;
                2'd1: wr_data = {27'd0, lf[20:16]};
                2'd2: wr_data = {29'd0, lf[18:16]};
                default: wr_data = {29'd0, lf[18:17], 1'b1};
            endcase
        end
        @(negedge clk);
        wr_en = 1'b0; evt_valid = 1'b0;
        wait_n(40);

        finish_run();
    end

endmodule